// File: doc/BRIEF.md
# Multi-core wait-for-event controller

This block tracks the low-power waiting of a group of cores. Each core owns a one-bit event mailbox and a small sleep state machine. Once an instruction commits, the core raises a one-cycle strobe: wait-for-event, wait-for-interrupt or send-event. A send-event from any core that is awake sets the mailbox of every core. A wait-for-event uses up a pending event if there is one. If there is none, the core goes to sleep until an event or an interrupt arrives. A wait-for-interrupt always puts the core to sleep, and only its interrupt wake input brings it back. Clock gating, interrupt prioritisation and instruction decode belong to the surrounding logic.

Each core runs one state machine with three states:
- `ST_RUN`: the core is awake.
- `ST_WAIT_EVT`: the core sleeps until an event or an interrupt.
- `ST_WAIT_IRQ`: the core sleeps until an interrupt.

The state machine has these transitions:
- *enter-event-wait* (`ST_RUN` to `ST_WAIT_EVT`): a wait-for-event commits while the mailbox is empty and no event is broadcast.
- *consume* (`ST_RUN` to `ST_RUN`): a wait-for-event commits while an event is pending or being broadcast. The mailbox clears.
- *enter-irq-wait* (`ST_RUN` to `ST_WAIT_IRQ`): a wait-for-interrupt commits.
- *event-wake* (`ST_WAIT_EVT` to `ST_RUN`): an event is broadcast. The event is consumed.
- *irq-wake* (`ST_WAIT_EVT` or `ST_WAIT_IRQ` to `ST_RUN`): the core's interrupt wake input asserts.

Both outputs are registered. Each one shows the effect of an input cycle on the next clock edge.

Top module: `wfe_ctrl`

## Requirements
- R1: After reset every bit of `sleeping_o` and `event_flag_o` is 0.
- R2: A send-event strobe from any awake core sets bit i of `event_flag_o` for every core i, including the sender. The bit is set one cycle later, unless that core consumes the event in the same cycle.
- R3: A wait-for-event strobe on an awake core whose event flag is 1 clears that flag. The core stays awake.
- R4: A wait-for-event strobe on an awake core whose event flag is 0, with no event broadcast in the same cycle, sets that core's `sleeping_o` bit on the next cycle.
- R5: A wait-for-interrupt strobe on an awake core sets its `sleeping_o` bit on the next cycle. This happens whatever the flag holds, and the flag keeps its value.
- R6: A core sleeping after wait-for-event wakes one cycle after a send-event from another core. Its flag stays 0 because the waking event is consumed.
- R7: A core sleeping after wait-for-event wakes one cycle after its `irq_wake_i` bit asserts.
- R8: A core sleeping after wait-for-interrupt stays asleep through send-events. Its flag still gets set. It wakes one cycle after its `irq_wake_i` bit asserts, and its flag keeps its value.
- R9: A send-event and a wait-for-event on the same awake core in the same cycle leave that core awake with its flag at 0.
- R10: Strobes from a sleeping core have no effect. A send-event from a sleeping core sets no flag.
- R11: A wait-for-event and a wait-for-interrupt on the same awake core in the same cycle act as a wait-for-interrupt. The flag is left unchanged.
- R12: An `irq_wake_i` bit on an awake core changes neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wfe_commit_i | input | NCORES | Committed wait-for-event strobe, one bit per core |
| wfi_commit_i | input | NCORES | Committed wait-for-interrupt strobe, one bit per core |
| sev_commit_i | input | NCORES | Committed send-event strobe, one bit per core |
| irq_wake_i | input | NCORES | Interrupt wake request, one bit per core |
| sleeping_o | output | NCORES | Core is in either sleep state |
| event_flag_o | output | NCORES | Current value of each core's event mailbox |

## Verification
The hardest situations to reach are the collisions. In one, a send-event lands in the same cycle as a wait-for-event on the same core. In another, a strobe comes from a core that is already asleep. Neither case changes the sleep state in a way the ports can easily see. The stimulus first builds a known mix of flags and sleep states across the cores: one core waiting for an event, one waiting for an interrupt, and some awake cores with their flags set or cleared. It then fires the colliding strobes. The next cycle's sleeping and flag vectors separate consumption from sleep and from an ignored broadcast.

// File: rtl/wfe_pkg.sv
package wfe_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_WAIT_EVT = 2'd1,
        ST_WAIT_IRQ = 2'd2
    } core_state_e;

endpackage

// File: rtl/wfe_sev_bcast.sv
module wfe_sev_bcast #(
    parameter int NCORES = 4
) (
    input  logic [NCORES-1:0] sev_i,
    input  logic [NCORES-1:0] awake_i,
    output logic              bcast_o
);

    logic [NCORES-1:0] qualified;

    // Only a core that is running can commit a send-event.
    always_comb begin
        qualified = sev_i & awake_i;
        bcast_o   = |qualified;
    end

endmodule

// File: rtl/wfe_core_fsm.sv
module wfe_core_fsm
    import wfe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wfe_i,
    input  logic wfi_i,
    input  logic bcast_i,
    input  logic irq_i,
    output logic asleep_o,
    output logic evt_o
);

    core_state_e st_q, st_d;
    logic        mb_q, mb_d;

    always_comb begin
        st_d = st_q;
        mb_d = mb_q;
        unique case (st_q)
            ST_RUN: begin
                if (wfi_i) begin
                    st_d = ST_WAIT_IRQ;
                    mb_d = mb_q | bcast_i;
                end else if (wfe_i) begin
                    if (mb_q || bcast_i) begin
                        mb_d = 1'b0;
                    end else begin
                        st_d = ST_WAIT_EVT;
                    end
                end else begin
                    mb_d = mb_q | bcast_i;
                end
            end
            ST_WAIT_EVT: begin
                if (bcast_i) begin
                    st_d = ST_RUN;
                    mb_d = 1'b0;
                end else if (irq_i) begin
                    st_d = ST_RUN;
                end
            end
            ST_WAIT_IRQ: begin
                mb_d = mb_q | bcast_i;
                if (irq_i) begin
                    st_d = ST_RUN;
                end
            end
            default: begin
                st_d = ST_RUN;
                mb_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RUN;
            mb_q <= 1'b0;
        end else begin
            st_q <= st_d;
            mb_q <= mb_d;
        end
    end

    always_comb begin
        asleep_o = (st_q != ST_RUN);
        evt_o    = mb_q;
    end

    // R6
    evt_wait_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_EVT) |-> !mb_q);

    // R3
    wfe_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && wfe_i && !wfi_i && (mb_q || bcast_i)) |=> (st_q == ST_RUN && !mb_q));

    // R4
    wfe_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && wfe_i && !wfi_i && !mb_q && !bcast_i) |=> (st_q == ST_WAIT_EVT));

    // R5
    wfi_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && wfi_i) |=> (st_q == ST_WAIT_IRQ && mb_q == $past(mb_q | bcast_i)));

    // R8
    irq_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_IRQ && !irq_i) |=> (st_q == ST_WAIT_IRQ));

    // R2
    bcast_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast_i && st_q == ST_WAIT_IRQ) |=> mb_q);

endmodule

// File: rtl/wfe_ctrl.sv
module wfe_ctrl #(
    parameter int NCORES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCORES-1:0] wfe_commit_i,
    input  logic [NCORES-1:0] wfi_commit_i,
    input  logic [NCORES-1:0] sev_commit_i,
    input  logic [NCORES-1:0] irq_wake_i,
    output logic [NCORES-1:0] sleeping_o,
    output logic [NCORES-1:0] event_flag_o
);

    logic [NCORES-1:0] asleep;
    logic [NCORES-1:0] awake;
    logic              bcast;

    always_comb awake = ~asleep;

    wfe_sev_bcast #(.NCORES(NCORES)) u_bcast (
        .sev_i   (sev_commit_i),
        .awake_i (awake),
        .bcast_o (bcast)
    );

    for (genvar gi = 0; gi < NCORES; gi++) begin : g_core
        wfe_core_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .wfe_i    (wfe_commit_i[gi]),
            .wfi_i    (wfi_commit_i[gi]),
            .bcast_i  (bcast),
            .irq_i    (irq_wake_i[gi]),
            .asleep_o (asleep[gi]),
            .evt_o    (event_flag_o[gi])
        );
    end

    always_comb sleeping_o = asleep;

    // R10
    sleeper_sev_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sev_commit_i & awake) == '0 && event_flag_o == '0) |=> (event_flag_o == '0));

endmodule

// File: tb/wfe_ctrl_tb.sv
`timescale 1ns/1ps
module wfe_ctrl_tb;

    localparam int N = 4;

    typedef struct {
        logic [N-1:0] slp;
        logic [N-1:0] flg;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] wfe = '0, wfi = '0, sev = '0, irq = '0;
    logic [N-1:0] sleeping, evflag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;

    wfe_ctrl #(.NCORES(N)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wfe_commit_i (wfe),
        .wfi_commit_i (wfi),
        .sev_commit_i (sev),
        .irq_wake_i   (irq),
        .sleeping_o   (sleeping),
        .event_flag_o (evflag)
    );

    task automatic compare(input logic [N-1:0] s, input logic [N-1:0] f, input string tag);
        checks++;
        if (sleeping !== s || evflag !== f) begin
            errors++;
            $display("FAIL %s: sleeping=%b flag=%b expected sleeping=%b flag=%b",
                     tag, sleeping, evflag, s, f);
        end
    endtask

    // Driver: apply one cycle of strobes and queue the expected result.
    task automatic step(input logic [N-1:0] e, input logic [N-1:0] i,
                        input logic [N-1:0] s, input logic [N-1:0] w,
                        input logic [N-1:0] xs, input logic [N-1:0] xf,
                        input string tag);
        exp_t it;
        @(negedge clk);
        wfe = e; wfi = i; sev = s; irq = w;
        it.slp = xs; it.flg = xf; it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: registered outputs settle just after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                compare(it.slp, it.flg, it.tag);
            end
        end
    end

    initial begin
        #(4 * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare('0, '0, "R1 during reset");
        rst_n = 1'b1;
        step('0, '0, '0, '0, 4'b0000, 4'b0000, "R1 idle");
        step('0, '0, 4'b0001, '0, 4'b0000, 4'b1111, "R2 broadcast incl sender");
        step(4'b0010, '0, '0, '0, 4'b0000, 4'b1101, "R3 wfe consumes");
        step(4'b0010, '0, '0, '0, 4'b0010, 4'b1101, "R4 wfe sleeps");
        step('0, 4'b0100, '0, '0, 4'b0110, 4'b1101, "R5 wfi sleeps with flag set");
        step('0, '0, '0, 4'b0001, 4'b0110, 4'b1101, "R12 irq on awake core");
        step(4'b0100, '0, 4'b0010, '0, 4'b0110, 4'b1101, "R10 sleeper strobes ignored");
        step('0, '0, 4'b1000, '0, 4'b0100, 4'b1101, "R6 event wake, R8 irq waiter stays");
        step('0, '0, '0, 4'b0100, 4'b0000, 4'b1101, "R8 irq wake keeps flag");
        step(4'b0010, '0, '0, '0, 4'b0010, 4'b1101, "R4 re-sleep");
        step('0, '0, '0, 4'b0010, 4'b0000, 4'b1101, "R7 irq wakes event waiter");
        step(4'b0010, '0, 4'b0001, '0, 4'b0000, 4'b1101, "R9 same-cycle sev and wfe");
        step(4'b0001, 4'b0001, '0, '0, 4'b0001, 4'b1101, "R11 wfi wins over wfe");
        step('0, '0, '0, 4'b0001, 4'b0000, 4'b1101, "R8 wake from wfi");
        step(4'b1101, '0, '0, '0, 4'b0000, 4'b0000, "R3 many cores consume");
        step('0, '0, 4'b0100, '0, 4'b0000, 4'b1111, "R2 broadcast from core 2");
        step('0, 4'b1111, '0, '0, 4'b1111, 4'b1111, "R5 all wfi");
        step('0, '0, 4'b1111, '0, 4'b1111, 4'b1111, "R10 all asleep sev ignored");
        step('0, '0, '0, '0, 4'b1111, 4'b1111, "R8 hold without irq");
        step('0, '0, '0, '0, 4'b1111, 4'b1111, "R8 hold");
        @(negedge clk);
        wfe = '0; wfi = '0; sev = '0; irq = '0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule